// File: doc/BRIEF.md
# Sprite Pattern Overlap Detector

This block decides whether two 8x8 monochrome sprite patterns touch at the pixel level. The caller knows the offset between the two top-left corners. The second sprite sits `dy` rows lower and `dx` columns further right than the first, with each offset between 0 and 7. Both patterns are written into internal row registers through a byte-wide write port, one row per write.

A start pulse captures the two offsets and begins a serial scan. On each clock the block takes one row of the first sprite, shifts it left by `dx` columns, and tests it against the matching row of the second sprite. The scan stops at the first row pair that shares a set pixel, or after the last pair if none does. The block then pulses `done` for one cycle. The `hit` flag carries the answer and keeps its value until the next accepted start.

The block is meant for a game engine's collision stage. A coarse bounding-box test has already found that the two 8x8 boxes overlap, and this block refines that result.

Top module: `sprite_overlap_detector`

## Requirements
- R1: A write with `wr_en` high while idle stores `wr_data` into row `wr_row` (0 = top) of the first sprite when `wr_sel` is 0, or of the second sprite when `wr_sel` is 1. Bit 7 is the leftmost pixel. The new row is used by any compare that starts at or after that clock edge.
- R2: A `start` sampled high while idle is accepted. On the following cycle `busy` is 1, `hit` is 0 and `done` is 0. `dx` and `dy` are captured at that edge.
- R3: Compare step k (k = 0, 1, …) pairs row `dy`+k of the first sprite with row k of the second sprite, one pair per clock. At most 8−`dy` pairs are compared.
- R4: Before the test, the first sprite's row is shifted left by `dx` columns. Bits pushed past the leftmost column are discarded and never cause a hit.
- R5: A row pair is a hit when at least one bit is set in both the shifted first-sprite row and the second-sprite row.
- R6: The scan stops at the first hit pair. If that is step k, `done` is high in the (k+2)-th cycle after the start edge, and `hit` is 1.
- R7: If no pair hits, `done` is high in the (9−`dy`)-th cycle after the start edge, and `hit` is 0.
- R8: `done` is high for exactly one cycle per compare. `hit` holds its value from that cycle until the next accepted start.
- R9: A `start` that arrives while `busy` is 1 has no effect. The running scan keeps its offsets and its timing.
- R10: A write that arrives while `busy` is 1 is discarded. No pattern row changes.
- R11: After reset, `busy`, `done` and `hit` are 0 and every row of both patterns is 0.
- R12: A `start` in the same cycle as the `done` pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Pattern row write strobe |
| wr_sel | input | 1 | 0 selects the first sprite, 1 the second |
| wr_row | input | 3 | Row index to write, 0 = top |
| wr_data | input | 8 | Row pixels, bit 7 leftmost |
| start | input | 1 | Begin a compare (sampled while idle) |
| dx | input | 3 | Column offset of the second sprite |
| dy | input | 3 | Row offset of the second sprite |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when a scan ends |
| hit | output | 1 | Result of the last finished scan |

## Verification
Two events can fall in the same cycle: the end of one scan, shown by the `done` pulse, and the acceptance of the next start. They can meet in two ways. In the first, the bench raises `start` in exactly the cycle where `done` is seen. It then checks that the next cycle shows `busy` high and `hit` cleared, and that the second scan keeps its own timing. In the second, a start or a write lands while a scan is still running. The bench judges this by the finish cycle and by the result of a later compare, which show that neither event disturbed the scan in flight. A per-cycle behavioural model compares `busy`, `done` and `hit` on every clock.

// File: rtl/sprov_pkg.sv
// Package: shared types of the sprite overlap detector.
package sprov_pkg;
    // Scan sequencer states
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_SCAN = 1'b1
    } sprov_state_e;
endpackage

// File: rtl/sprov_pattern_store.sv
// Module: sprov_pattern_store
// Holds the two sprite patterns as ROWS registers of COLS bits each and
// serves two combinational row reads. Writes are dropped while lock is high.
// Assumes ROWS is a power of two so that every row index value is valid.
module sprov_pattern_store #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [RW-1:0]   wr_row,
    input  logic [COLS-1:0] wr_data,
    input  logic            lock,
    input  logic [RW-1:0]   rd_idx_a,
    input  logic [RW-1:0]   rd_idx_b,
    output logic [COLS-1:0] rd_row_a,
    output logic [COLS-1:0] rd_row_b
);
    logic [ROWS-1:0][COLS-1:0] bank_a;
    logic [ROWS-1:0][COLS-1:0] bank_b;
    logic                      wr_ok;

    // Qualify the write strobe with the lock from the sequencer
    assign wr_ok = wr_en && !lock;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [COLS-1:0] first_q;
            logic [COLS-1:0] second_q;

            // Row register of the first sprite
            always_ff @(posedge clk) begin
                if (!rst_n)
                    first_q <= '0;
                else if (wr_ok && !wr_sel && wr_row == RW'(r))
                    first_q <= wr_data;
            end

            // Row register of the second sprite
            always_ff @(posedge clk) begin
                if (!rst_n)
                    second_q <= '0;
                else if (wr_ok && wr_sel && wr_row == RW'(r))
                    second_q <= wr_data;
            end

            assign bank_a[r] = first_q;
            assign bank_b[r] = second_q;
        end
    endgenerate

    // Read muxes feeding the aligner
    assign rd_row_a = bank_a[rd_idx_a];
    assign rd_row_b = bank_b[rd_idx_b];

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> ($stable(bank_a) && $stable(bank_b))); // R10
endmodule

// File: rtl/sprov_row_aligner.sv
// Module: sprov_row_aligner
// Shifts one row of the first sprite left by the column offset and tests it
// against the matching row of the second sprite. Bits leaving the left edge
// are dropped. Purely combinational.
module sprov_row_aligner #(
    parameter int COLS = 8,
    parameter int SW   = $clog2(COLS)
) (
    input  logic [COLS-1:0] row_a,
    input  logic [COLS-1:0] row_b,
    input  logic [SW-1:0]   shift,
    output logic            overlap
);
    logic [COLS-1:0] shifted;

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // Column c takes source column c-shift, or zero past the right edge
            always_comb begin
                if (int'(shift) <= c)
                    shifted[c] = row_a[c - int'(shift)];
                else
                    shifted[c] = 1'b0;
            end
        end
    endgenerate

    // Any common set pixel marks the pair as touching
    assign overlap = |(shifted & row_b);
endmodule

// File: rtl/sprov_scan_ctrl.sv
// Module: sprov_scan_ctrl
// Sequencer for one overlap scan. It captures the offsets on an accepted
// start, steps the row pair index once per clock, and stops at the first
// overlap or at the last valid pair. A start while scanning is ignored.
module sprov_scan_ctrl
    import sprov_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int RW   = $clog2(ROWS),
    parameter int SW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] dx,
    input  logic [RW-1:0] dy,
    input  logic          overlap,
    output logic [RW-1:0] idx_a,
    output logic [RW-1:0] idx_b,
    output logic [SW-1:0] shift,
    output logic          busy,
    output logic          done,
    output logic          hit
);
    localparam logic [RW:0] LAST_ROW = (RW+1)'(ROWS - 1);

    sprov_state_e  state_q;
    logic [RW-1:0] step_q;
    logic [SW-1:0] dx_q;
    logic [RW-1:0] dy_q;
    logic          done_q;
    logic          hit_q;
    logic [RW:0]   row_sum;
    logic          last_pair;

    // Row of the first sprite is offset by dy; both advance together
    assign row_sum   = {1'b0, step_q} + {1'b0, dy_q};
    assign last_pair = (row_sum == LAST_ROW);
    assign idx_a     = row_sum[RW-1:0];
    assign idx_b     = step_q;
    assign shift     = dx_q;
    assign busy      = (state_q == SQ_SCAN);
    assign done      = done_q;
    assign hit       = hit_q;

    // Scan state machine with result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            dx_q    <= '0;
            dy_q    <= '0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_SCAN;
                        step_q  <= '0;
                        dx_q    <= dx;
                        dy_q    <= dy;
                        hit_q   <= 1'b0;
                    end
                end
                default: begin
                    if (overlap || last_pair) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                        hit_q   <= overlap;
                    end else begin
                        step_q <= step_q + RW'(1);
                    end
                end
            endcase
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !hit && !done)); // R2
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (row_sum <= LAST_ROW)); // R3
    AST_DONE_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_HIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(hit)); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dx_q) && $stable(dy_q))); // R9
endmodule

// File: rtl/sprite_overlap_detector.sv
// Module: sprite_overlap_detector
// Top level: pattern store, row aligner and scan sequencer. The second sprite
// is assumed to lie at or below and at or right of the first.
module sprite_overlap_detector #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [$clog2(ROWS)-1:0]  wr_row,
    input  logic [COLS-1:0]          wr_data,
    input  logic                     start,
    input  logic [$clog2(COLS)-1:0]  dx,
    input  logic [$clog2(ROWS)-1:0]  dy,
    output logic                     busy,
    output logic                     done,
    output logic                     hit
);
    localparam int RW = $clog2(ROWS);
    localparam int SW = $clog2(COLS);

    logic [RW-1:0]   idx_a;
    logic [RW-1:0]   idx_b;
    logic [SW-1:0]   shift;
    logic [COLS-1:0] row_a;
    logic [COLS-1:0] row_b;
    logic            overlap;
    logic            busy_w;

    assign busy = busy_w;

    sprov_pattern_store #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_row   (wr_row),
        .wr_data  (wr_data),
        .lock     (busy_w),
        .rd_idx_a (idx_a),
        .rd_idx_b (idx_b),
        .rd_row_a (row_a),
        .rd_row_b (row_b)
    );

    sprov_row_aligner #(.COLS(COLS), .SW(SW)) u_align (
        .row_a   (row_a),
        .row_b   (row_b),
        .shift   (shift),
        .overlap (overlap)
    );

    sprov_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .SW(SW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .dx      (dx),
        .dy      (dy),
        .overlap (overlap),
        .idx_a   (idx_a),
        .idx_b   (idx_b),
        .shift   (shift),
        .busy    (busy_w),
        .done    (done),
        .hit     (hit)
    );
endmodule

// File: tb/sprite_overlap_detector_tb_top.sv
module sprite_overlap_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [2:0] wr_row = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic [2:0] dx = '0;
    logic [2:0] dy = '0;
    logic       busy, done, hit;

    int n_run = 0;
    int n_fail = 0;
    bit chk_on = 0;

    // behavioural reference state
    int m_first [8];
    int m_second[8];
    int m_busy = 0, m_done = 0, m_hit = 0, m_k = 0, m_dx = 0, m_dy = 0;

    always #4 clk = ~clk;

    sprite_overlap_detector dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_row(wr_row), .wr_data(wr_data), .start(start), .dx(dx), .dy(dy),
        .busy(busy), .done(done), .hit(hit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // cycle model, updated on each rising edge from the driven inputs
    always @(posedge clk) begin
        int was_busy;
        int a, b;
        was_busy = m_busy;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_hit = 0; m_k = 0;
            for (int i = 0; i < 8; i++) begin m_first[i] = 0; m_second[i] = 0; end
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                a = m_first[m_dy + m_k];
                b = m_second[m_k];
                if ((((a << m_dx) & 255) & b) != 0) begin
                    m_busy = 0; m_done = 1; m_hit = 1;
                end else if (m_dy + m_k == 7) begin
                    m_busy = 0; m_done = 1; m_hit = 0;
                end else m_k++;
            end else if (start) begin
                m_busy = 1; m_k = 0; m_dx = int'(dx); m_dy = int'(dy); m_hit = 0;
            end
            if (was_busy == 0 && wr_en) begin
                if (wr_sel) m_second[wr_row] = int'(wr_data);
                else m_first[wr_row] = int'(wr_data);
            end
        end
    end

    // compare the design with the model every cycle, away from the edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2", "busy vs model", int'(busy), m_busy);
            chk("R8", "done vs model", int'(done), m_done);
            chk("R6", "hit vs model", int'(hit), m_hit);
        end
    end

    task automatic wr(input bit sel, input int row, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_row = 3'(row); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [63:0] fa, input logic [63:0] fb);
        for (int r = 0; r < 8; r++) wr(1'b0, r, int'(fa[63-8*r -: 8]));
        for (int r = 0; r < 8; r++) wr(1'b1, r, int'(fb[63-8*r -: 8]));
    endtask

    // pulse start, count cycles to done, check wait and result
    task automatic run_cmp(input int x, input int y, input int exp_hit,
                           input int exp_wait, input string req);
        int w;
        @(negedge clk);
        dx = 3'(x); dy = 3'(y); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 1;
        while (!done && w < 20) begin @(negedge clk); w++; end
        chk(req, "cycles to done", w, exp_wait);
        chk(req, "hit", int'(hit), exp_hit);
    endtask

    function automatic int ref_wait(input int fa[8], input int fb[8],
                                    input int x, input int y, output int h);
        h = 0;
        for (int k = 0; k < 8 - y; k++)
            if ((((fa[y+k] << x) & 255) & fb[k]) != 0) begin h = 1; return k + 2; end
        return 9 - y;
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R6 watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int w, h, seed;
        int fa[8], fb[8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1;
        // R11 reset state
        chk("R11", "busy after reset", int'(busy), 0);
        chk("R11", "done after reset", int'(done), 0);
        chk("R11", "hit after reset", int'(hit), 0);
        run_cmp(0, 0, 0, 9, "R11 cleared patterns");

        // R5 R6 ball over ship example, first pair touches
        load(64'h3C7EFFFFFFFF7E3C, 64'h1818181818_7EFFFF);
        run_cmp(4, 4, 1, 2, "R5 R6");
        // R8 hit held while idle
        repeat (5) @(negedge clk);
        chk("R8", "hit held", int'(hit), 1);
        chk("R8", "done low when idle", int'(done), 0);

        // R4 shift alignment and discarded bits
        load(64'h0F0F0F0F0F0F0F0F, 64'h0F0F0F0F0F0F0F0F);
        run_cmp(4, 0, 0, 9, "R4 R7 shifted apart");
        run_cmp(3, 0, 1, 2, "R4 one column overlap");
        load(64'hF0F0F0F0F0F0F0F0, 64'hFFFFFFFFFFFFFFFF);
        run_cmp(4, 0, 0, 9, "R4 bits past left edge");
        run_cmp(3, 0, 1, 2, "R4 one bit left");

        // R3 row pairing
        load(64'h0000000000010000, 64'h0000000100000000);
        run_cmp(0, 2, 1, 5, "R3 pair at step 3");
        run_cmp(0, 3, 0, 6, "R3 R7 misaligned rows");
        load(64'h0000000000000040, 64'h8000000000000000);
        run_cmp(1, 7, 1, 2, "R3 single pair dy 7");
        run_cmp(0, 7, 0, 2, "R7 single pair no hit");

        // R10 write during scan is dropped
        @(negedge clk);
        dx = 3'd0; dy = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wr(1'b1, 7, 8'h40);
        w = 3;
        while (!done && w < 20) begin @(negedge clk); w++; end
        chk("R10", "cycles to done", w, 9);
        chk("R10", "hit", int'(hit), 0);
        run_cmp(0, 0, 0, 9, "R10 row unchanged");
        wr(1'b1, 7, 8'h40);
        run_cmp(0, 0, 1, 9, "R1 idle write used");

        // R9 start while busy ignored
        @(negedge clk);
        dx = 3'd0; dy = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dx = 3'd1; dy = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 3;
        while (!done && w < 20) begin @(negedge clk); w++; end
        chk("R9", "cycles to done", w, 9);
        chk("R9", "hit", int'(hit), 1);
        @(negedge clk);
        chk("R9", "idle after done", int'(busy), 0);

        // R12 start in the done cycle
        run_cmp(0, 6, 0, 3, "R12 first scan");
        dx = 3'd1; dy = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12", "busy after chained start", int'(busy), 1);
        chk("R12", "hit cleared", int'(hit), 0);
        w = 1;
        while (!done && w < 20) begin @(negedge clk); w++; end
        chk("R12", "cycles to done", w, 2);
        chk("R12", "hit", int'(hit), 1);

        // random patterns against the behavioural result
        seed = 12345;
        for (int t = 0; t < 150; t++) begin
            for (int r = 0; r < 8; r++) begin
                seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
                fa[r] = (seed >> 8) & ((t % 3 == 0) ? 255 : 36);
                seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
                fb[r] = (seed >> 8) & ((t % 3 == 0) ? 255 : 66);
                wr(1'b0, r, fa[r]);
                wr(1'b1, r, fb[r]);
            end
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            w = ref_wait(fa, fb, (seed >> 4) & 7, (seed >> 9) & 7, h);
            run_cmp((seed >> 4) & 7, (seed >> 9) & 7, h, w, "R3 R4 R5 R6 R7 random");
        end

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule